// File: doc/BRIEF.md
# Trigger Interpolator Interval Counter

This block measures where an asynchronous trigger falls between two sample clock edges, to a resolution much finer than one sample period. Once armed by the host, the first rising edge of the trigger starts a gate pulse to an external time stretcher. The gate ends at the next sample edge, so its width is the sub-sample interval plus the synchronizer latency. The stretcher then takes a time proportional to that width, roughly a thousand times longer. During that time the block counts cycles of a clock derived from the sample oscillator.

When the stretcher reports completion, the count is latched together with a valid flag. The acquisition logic uses this value to place captured data relative to the trigger point. If completion never arrives, a timeout ends the measurement and raises an overflow flag. Reading the result clears the flags and returns the block to idle, where it waits for the next arm. The sample edge is supplied as a one-cycle strobe in the counting clock domain.

Top module: `trig_interp_counter`

## Requirements
- R1: While reset is held and after it is released, `gate_o`, `res_vld` and `res_ovf` are 0 and `res_cnt` is 0.
- R2: When armed, a rising edge on `trig_in` drives `gate_o` high on the third clock edge after the change (two synchronizer flops plus the edge detector). `gate_o` falls on the first later edge at which `smp_tick` is sampled high. A strobe presented k cycles after the gate is seen high therefore gives a gate of k+1 cycles.
- R3: A trigger edge is ignored in the idle state, while a result is held, and during a measurement already under way. In these cases `gate_o` stays low and a held result does not change.
- R4: Let N be the number of full clock periods between `gate_o` falling and `stretch_done` rising. Then `res_cnt` = N+2, and `res_vld` rises on the third clock edge after `stretch_done` rises.
- R5: The count saturates at 2^CNT_W-1. A longer stretch yields all ones, with `res_ovf` left at 0.
- R6: If `stretch_done` does not rise, the measurement ends on the (TMO_CYC+1)-th edge after the gate-falling edge. At that point `res_vld`=1, `res_ovf`=1 and `res_cnt` = min(TMO_CYC, 2^CNT_W-1).
- R7: While `res_vld` is 1 and `rd` is low, `res_cnt` and the flags hold. A `rd` pulse clears `res_vld` and `res_ovf` on the next edge.
- R8: `arm` is accepted only in the idle state. An `arm` pulse while a result is held has no effect, so after the following `rd` a trigger edge produces no gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock derived from the sample oscillator |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | 1 | Asynchronous trigger event |
| smp_tick | input | 1 | One-cycle strobe marking a sample clock edge |
| stretch_done | input | 1 | Asynchronous completion from the time stretcher |
| arm | input | 1 | Host pulse: arm for the next trigger |
| rd | input | 1 | Host pulse: result consumed |
| gate_o | output | 1 | Registered gate pulse to the stretcher |
| res_cnt | output | CNT_W | Latched interval count |
| res_ovf | output | 1 | Measurement ended by timeout |
| res_vld | output | 1 | Result valid |

## Verification
The gate is due on the third edge after the trigger is driven. It ends one edge after the sample strobe. The result is valid on the third edge after completion, or on edge TMO_CYC+1 after the gate falls if completion never comes. Flags clear one edge after a read. The bench drives every input at a falling edge and counts falling edges from that point. It checks each output one period before its due edge, to confirm it is still low, and again just after that edge. Expected counts are computed as N+2, clipped to the counter maximum, over a sweep of gate widths and stretch factors.

// File: rtl/tic_pkg.sv
package tic_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARMED = 3'd1,
    ST_GATE  = 3'd2,
    ST_COUNT = 3'd3,
    ST_DONE  = 3'd4
  } tic_state_e;
endpackage

// File: rtl/tic_rst_sync.sv
module tic_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] rs_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rs_q <= 2'b00;
    else         rs_q <= {rs_q[0], 1'b1};
  end

  assign rst_n_o = rs_q[1];
endmodule

// File: rtl/tic_sync.sv
module tic_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    logic [W-1:0] stg_d;
    if (i == 0) begin : g_first
      assign stg_d = d;
    end else begin : g_rest
      assign stg_d = stg_q[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[i] <= '0;
      else        stg_q[i] <= stg_d;
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/tic_count.sv
module tic_count #(
  parameter int CNT_W   = 16,
  parameter int TMO_CYC = 50000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  output logic [CNT_W-1:0] cnt,
  output logic             tmo_hit
);
  localparam int TMO_W = $clog2(TMO_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [TMO_W-1:0] TMO_LIM = TMO_W'(TMO_CYC);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [TMO_W-1:0] tmo_q, tmo_d;
  logic             cnt_en, tmo_en;

  always_comb begin
    cnt_en = clr | (run & (cnt_q != CNT_MAX));
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
    tmo_en = clr | (run & (tmo_q != TMO_LIM));
    tmo_d  = clr ? '0 : tmo_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tmo_q <= '0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      if (tmo_en) tmo_q <= tmo_d;
    end
  end

  assign cnt     = cnt_q;
  assign tmo_hit = run & (tmo_q == TMO_LIM);
endmodule

// File: rtl/tic_ctrl.sv
module tic_ctrl
  import tic_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             rd,
  input  logic             trig_s,
  input  logic             done_s,
  input  logic             smp_tick,
  input  logic [CNT_W-1:0] cnt,
  input  logic             tmo_hit,
  output logic             gate,
  output logic             cnt_clr,
  output logic             cnt_run,
  output logic [CNT_W-1:0] res_cnt,
  output logic             res_ovf,
  output logic             res_vld,
  output tic_state_e       state
);
  tic_state_e       st_q, st_d;
  logic             trig_prev_q, done_prev_q;
  logic             trig_rise, done_rise;
  logic             gate_q, gate_d;
  logic [CNT_W-1:0] res_q, res_d;
  logic             ovf_q, ovf_d, vld_q, vld_d, res_en;

  assign trig_rise = trig_s & ~trig_prev_q;
  assign done_rise = done_s & ~done_prev_q;

  always_comb begin
    st_d   = st_q;
    res_d  = res_q;
    ovf_d  = ovf_q;
    vld_d  = vld_q;
    res_en = 1'b0;
    unique case (st_q)
      ST_IDLE:  if (arm) st_d = ST_ARMED;
      ST_ARMED: if (trig_rise) st_d = ST_GATE;
      ST_GATE:  if (smp_tick) st_d = ST_COUNT;
      ST_COUNT: begin
        if (done_rise) begin
          st_d = ST_DONE; res_en = 1'b1;
          res_d = cnt; ovf_d = 1'b0; vld_d = 1'b1;
        end else if (tmo_hit) begin
          st_d = ST_DONE; res_en = 1'b1;
          res_d = cnt; ovf_d = 1'b1; vld_d = 1'b1;
        end
      end
      ST_DONE: begin
        if (rd) begin
          st_d = ST_IDLE; res_en = 1'b1;
          ovf_d = 1'b0; vld_d = 1'b0;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    gate_d = (st_d == ST_GATE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      trig_prev_q <= 1'b0;
      done_prev_q <= 1'b0;
      gate_q      <= 1'b0;
      res_q       <= '0;
      ovf_q       <= 1'b0;
      vld_q       <= 1'b0;
    end else begin
      st_q        <= st_d;
      trig_prev_q <= trig_s;
      done_prev_q <= done_s;
      gate_q      <= gate_d;
      if (res_en) begin
        res_q <= res_d;
        ovf_q <= ovf_d;
        vld_q <= vld_d;
      end
    end
  end

  assign gate    = gate_q;
  assign cnt_clr = (st_q == ST_GATE) & smp_tick;
  assign cnt_run = (st_q == ST_COUNT);
  assign res_cnt = res_q;
  assign res_ovf = ovf_q;
  assign res_vld = vld_q;
  assign state   = st_q;
endmodule

// File: rtl/trig_interp_counter.sv
module trig_interp_counter
  import tic_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int TMO_CYC  = 50000,
  parameter int SYNC_STG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_in,
  input  logic             smp_tick,
  input  logic             stretch_done,
  input  logic             arm,
  input  logic             rd,
  output logic             gate_o,
  output logic [CNT_W-1:0] res_cnt,
  output logic             res_ovf,
  output logic             res_vld
);
  logic             rst_n_s;
  logic [1:0]       async_in, sync_out;
  logic             cnt_clr, cnt_run, tmo_hit;
  logic [CNT_W-1:0] cnt_w;
  tic_state_e       state_w;

  tic_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_n_s)
  );

  assign async_in = {stretch_done, trig_in};

  tic_sync #(.W(2), .STAGES(SYNC_STG)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_s),
    .d     (async_in),
    .q     (sync_out)
  );

  tic_count #(.CNT_W(CNT_W), .TMO_CYC(TMO_CYC)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .clr     (cnt_clr),
    .run     (cnt_run),
    .cnt     (cnt_w),
    .tmo_hit (tmo_hit)
  );

  tic_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .arm      (arm),
    .rd       (rd),
    .trig_s   (sync_out[0]),
    .done_s   (sync_out[1]),
    .smp_tick (smp_tick),
    .cnt      (cnt_w),
    .tmo_hit  (tmo_hit),
    .gate     (gate_o),
    .cnt_clr  (cnt_clr),
    .cnt_run  (cnt_run),
    .res_cnt  (res_cnt),
    .res_ovf  (res_ovf),
    .res_vld  (res_vld),
    .state    (state_w)
  );
endmodule

// File: rtl/tic_chk.sv
module tic_chk
  import tic_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             smp_tick,
  input logic             rd,
  input logic             gate_o,
  input logic [CNT_W-1:0] res_cnt,
  input logic             res_ovf,
  input logic             res_vld,
  input logic             cnt_run,
  input logic [CNT_W-1:0] cnt,
  input tic_state_e       state
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  p_gate_armed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_o) |-> $past(state) == ST_ARMED);

  p_gate_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate_o) |-> $past(smp_tick));

  p_no_gate_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE) |=> !gate_o);

  p_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_run && cnt == CNT_MAX) |=> cnt == CNT_MAX);

  p_ovf_vld_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_ovf |-> res_vld);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && !rd) |=> (res_vld && $stable(res_cnt)));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && rd) |=> (!res_vld && !res_ovf));
endmodule

bind trig_interp_counter tic_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .smp_tick (smp_tick),
  .rd       (rd),
  .gate_o   (gate_o),
  .res_cnt  (res_cnt),
  .res_ovf  (res_ovf),
  .res_vld  (res_vld),
  .cnt_run  (cnt_run),
  .cnt      (cnt_w),
  .state    (state_w)
);

// File: tb/sim_trig_interp_counter.sv
`timescale 1ns/1ps
module sim_trig_interp_counter;
  localparam int CNT_W   = 8;
  localparam int TMO_CYC = 300;
  localparam int MAXV    = (1 << CNT_W) - 1;

  logic clk, rst_n, trig_in, smp_tick, stretch_done, arm, rd;
  logic gate_o, res_ovf, res_vld;
  logic [CNT_W-1:0] res_cnt;
  int total = 0;
  int bad   = 0;
  bit ended = 0;

  trig_interp_counter #(.CNT_W(CNT_W), .TMO_CYC(TMO_CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .smp_tick(smp_tick),
    .stretch_done(stretch_done), .arm(arm), .rd(rd), .gate_o(gate_o),
    .res_cnt(res_cnt), .res_ovf(res_ovf), .res_vld(res_vld));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // k: strobe delay after gate seen high; d: stretch delay; no_done: timeout case
  task automatic measure(int k, int d, bit no_done, bit extra);
    int exp_cnt;
    @(negedge clk); arm = 1'b1;
    @(negedge clk); arm = 1'b0; trig_in = 1'b1;
    wait_n(2);
    chk("R2", "gate before third edge", int'(gate_o), 0);
    wait_n(1);
    chk("R2", "gate after third edge", int'(gate_o), 1);
    trig_in = 1'b0;
    wait_n(k);
    chk("R2", "gate held until strobe", int'(gate_o), 1);
    smp_tick = 1'b1;
    @(negedge clk); smp_tick = 1'b0;
    chk("R2", "gate falls after strobe", int'(gate_o), 0);
    trig_in = extra;   // R3: edge during the count must be ignored
    if (!no_done) begin
      wait_n(d);
      stretch_done = 1'b1;
      wait_n(2);
      chk("R4", "valid before third edge", int'(res_vld), 0);
      wait_n(1);
      stretch_done = 1'b0;
      exp_cnt = (d + 2 > MAXV) ? MAXV : d + 2;
      chk("R4", "valid on third edge", int'(res_vld), 1);
      chk((d + 2 > MAXV) ? "R5" : "R4", "count", int'(res_cnt), exp_cnt);
      chk("R5", "no overflow on completion", int'(res_ovf), 0);
    end else begin
      wait_n(TMO_CYC);
      chk("R6", "valid before timeout", int'(res_vld), 0);
      wait_n(1);
      exp_cnt = (TMO_CYC > MAXV) ? MAXV : TMO_CYC;
      chk("R6", "valid at timeout", int'(res_vld), 1);
      chk("R6", "overflow at timeout", int'(res_ovf), 1);
      chk("R6", "count at timeout", int'(res_cnt), exp_cnt);
    end
    // R3: trigger while result held; R8: arm while held is ignored
    trig_in = 1'b0; wait_n(3);
    trig_in = 1'b1; arm = 1'b1;
    @(negedge clk); arm = 1'b0;
    wait_n(4);
    chk("R3", "no gate while held", int'(gate_o), 0);
    chk("R7", "result held", int'(res_cnt), exp_cnt);
    chk("R7", "valid held", int'(res_vld), 1);
    rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    chk("R7", "valid cleared by read", int'(res_vld), 0);
    chk("R7", "overflow cleared by read", int'(res_ovf), 0);
    trig_in = 1'b0; wait_n(3);
    trig_in = 1'b1; wait_n(5);
    chk("R8", "no gate after ignored arm", int'(gate_o), 0);
    trig_in = 1'b0; wait_n(4);
  endtask

  initial begin
    int facs [3] = '{0, 2, 9};
    rst_n = 1'b0; trig_in = 1'b0; smp_tick = 1'b0;
    stretch_done = 1'b0; arm = 1'b0; rd = 1'b0;
    wait_n(3);
    chk("R1", "gate in reset", int'(gate_o), 0);
    chk("R1", "valid in reset", int'(res_vld), 0);
    rst_n = 1'b1;
    wait_n(4);
    chk("R1", "gate after reset", int'(gate_o), 0);
    chk("R1", "valid after reset", int'(res_vld), 0);
    chk("R1", "overflow after reset", int'(res_ovf), 0);
    chk("R1", "count after reset", int'(res_cnt), 0);
    // R3: trigger while idle
    trig_in = 1'b1; wait_n(5);
    chk("R3", "no gate when idle", int'(gate_o), 0);
    rd = 1'b1; @(negedge clk); rd = 1'b0;
    chk("R7", "read without result", int'(res_vld), 0);
    trig_in = 1'b0; wait_n(4);
    for (int k = 0; k < 4; k++)
      for (int f = 0; f < 3; f++)
        measure(k, facs[f] * (k + 1), 1'b0, f[0]);
    measure(6, 40 * 7, 1'b0, 1'b1);   // R5: saturating stretch
    measure(2, 0, 1'b1, 1'b0);        // R6: no completion
    finish_run();
  end

  initial begin
    wait_n(100000);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end
endmodule